// File: doc/BRIEF.md
# Partitionable Set-Associative Cache with On-Chip RAM Mode

This block is a 4 KB mixed instruction/data cache. It is built from four ways of 64 sets, with 16-byte lines of four 32-bit words. A CPU-side port takes single-word reads and writes. A request is held until `cpuReady` pulses. Read misses fill a whole line from external memory, one word transaction at a time. Writes always go through to external memory. A write hit also updates the cached copy. A write miss leaves the cache unchanged.

A two-bit control register sets the organisation. Bit 0 chooses two-way mode and bit 1 is a purge strobe. In two-way mode, ways 2 and 3 keep working as a two-way cache with the same least-recently-used rules. Ways 0 and 1 become 2 KB of directly addressed RAM, reached through a fixed address window with no tag compare.

Two address regions bypass the cache. A test-and-set access goes straight to external memory as a locked read-modify-write. A single line can be invalidated by address, and the whole cache can be purged at once.

Top module: `split_cache`

## Requirements
- R1: After reset, `cpuReady`, `memReq` and `memLock` are low, the block is in four-way mode, and every line is invalid.
- R2: A cacheable read miss fetches its line as four word reads at the line base, offsets 0, 4, 8 and 12 in that order. It then returns the requested word. A later read of any word in that line returns `cpuReady` in the same cycle as the request, with no external traffic.
- R3: In four-way mode, after a purge, a set fills way 3, then 2, then 1, then 0. After that, a miss replaces the least recently used way of the set. Read hits, write hits and fills all count as uses.
- R4: Every cacheable write does exactly one external write with the CPU address and data. A write hit also updates the cached word. A write miss allocates nothing.
- R5: Addresses with bits [31:29] = 3'b001 bypass the cache. Each read does one external read and each write does one external write. Nothing is cached.
- R6: A control write sets the mode from bit 0. When bit 1 is 1, the write clears every valid bit and every LRU bit. The purge bit is not kept, and the mode stays as written.
- R7: A purge command with a line address (address bits [31:4]) invalidates only the cache line holding that address. Other lines in the same set stay valid.
- R8: In two-way mode only ways 3 and 2 cache data. After a purge, the first fill of a set goes to way 3 and the second to way 2. Later misses replace the least recently used of the two.
- R9: The RAM window has bits [31:29] = 3'b110. In two-way mode, a word there is at way = bit 10 (0 or 1), set = bits [9:4], word = bits [3:2]. It is read or written with `cpuReady` in the request cycle and no external traffic. It is never disturbed by cache fills. In four-way mode the window is an uncached external access.
- R10: A test-and-set access (`cpuAtomic`) ignores the cache. It does one external read and then one external write to the same address, writing the read value with bit 31 set. `memLock` is held from the read through the end of the write. The CPU receives the value read.
- R11: An external request holds `memReq`, `memAddr` and `memWe` steady until `memAck`.
- R12: At most one cache way matches the CPU address at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU request, held until `cpuReady` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAtomic | input | 1 | Test-and-set access |
| cpuAddr | input | 32 | Byte address (word aligned) |
| cpuWdata | input | 32 | Write data |
| cpuRdata | output | 32 | Read data, valid with `cpuReady` |
| cpuReady | output | 1 | Access complete |
| ctlWe | input | 1 | Control register write strobe |
| ctlWdata | input | 2 | Bit 0 two-way mode, bit 1 purge all |
| purgeReq | input | 1 | Invalidate one line |
| purgeLineAddr | input | 28 | Line address (bits [31:4]) to invalidate |
| memReq | output | 1 | External request |
| memWe | output | 1 | External write |
| memLock | output | 1 | External bus locked (test-and-set) |
| memAddr | output | 32 | External word address |
| memWdata | output | 32 | External write data |
| memRdata | input | 32 | External read data, valid with `memAck` |
| memAck | input | 1 | External transfer complete |

## Verification
The assertions check three things on every cycle. External requests must stay steady until acknowledged. The lock must only appear together with a request, and a locked write must carry bit 31. A RAM-window access in two-way mode must never reach the external port, and no two ways may match at once. Fill order, LRU victim choice in both modes, write-through with and without allocation, the purges and the test-and-set data path depend on the history of accesses. Only the bench scenarios show those, by counting external transfers and checking returned data.

// File: rtl/split_cache_pkg.sv
`timescale 1ns/1ps
package split_cache_pkg;
  localparam int AW        = 32;
  localparam int DW        = 32;
  localparam int NWAYS     = 4;
  localparam int WAY_BITS  = 2;
  localparam int SET_BITS  = 6;
  localparam int WORD_BITS = 2;
  localparam int NSETS     = 1 << SET_BITS;
  localparam int NWORDS    = 1 << WORD_BITS;
  localparam int OFF_BITS  = WORD_BITS + 2;
  localparam int TAG_LSB   = OFF_BITS + SET_BITS;
  localparam int TAG_W     = AW - TAG_LSB;
  localparam int LINE_W    = AW - OFF_BITS;
  localparam int LRU_W     = NWAYS * (NWAYS - 1) / 2;
  localparam logic [2:0] REGION_THRU = 3'b001;
  localparam logic [2:0] REGION_RAM  = 3'b110;

  typedef struct packed {
    logic lruTouch;   // mark hit way most recent
    logic fillStart;  // latch victim way
    logic fillAddr;   // external address = line base + fill counter
    logic fillWrite;  // store returned word into victim line
    logic fillDone;   // write tag, set valid, touch victim
    logic writeHit;   // update cached word on write-through
    logic ramWrite;   // write into RAM window
    logic purgeLine;  // invalidate one line by address
    logic capture;    // latch external read data
    logic tasData;    // external write data = captured | bit 31
    logic selCap;     // CPU read data from capture register
  } ctlStrobes_t;
endpackage

// File: rtl/split_cache_dp.sv
`timescale 1ns/1ps
module split_cache_dp
  import split_cache_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strb,
  input  logic [WORD_BITS-1:0] fillCnt,
  input  logic [AW-1:0]        cpuAddr,
  input  logic [DW-1:0]        cpuWdata,
  input  logic                 ctlWe,
  input  logic [1:0]           ctlWdata,
  input  logic [LINE_W-1:0]    purgeLineAddr,
  input  logic [DW-1:0]        memRdata,
  output logic [DW-1:0]        cpuRdata,
  output logic [AW-1:0]        memAddr,
  output logic [DW-1:0]        memWdata,
  output logic                 twoWay,
  output logic [NWAYS-1:0]     hitVec,
  output logic                 ramAcc,
  output logic                 throughAcc
);
  logic [DW-1:0]     dataArr [NWAYS][NSETS][NWORDS];
  logic [TAG_W-1:0]  tagArr  [NWAYS][NSETS];
  logic [NWAYS-1:0]  validArr [NSETS];
  logic [LRU_W-1:0]  lruArr   [NSETS];
  logic [WAY_BITS-1:0] victimReg, hitWay, ramWay, victimNow;
  logic [DW-1:0]     capReg;
  logic [NWAYS-1:0]  purgeHit, cacheMask;

  wire [SET_BITS-1:0]  setIdx  = cpuAddr[TAG_LSB-1:OFF_BITS];
  wire [WORD_BITS-1:0] wordIdx = cpuAddr[OFF_BITS-1:2];
  wire [TAG_W-1:0]     tagIn   = cpuAddr[AW-1:TAG_LSB];
  wire [2:0]           region  = cpuAddr[AW-1:AW-3];
  wire [SET_BITS-1:0]  pSet    = purgeLineAddr[SET_BITS-1:0];
  wire [TAG_W-1:0]     pTag    = purgeLineAddr[LINE_W-1:SET_BITS];
  wire                 purgeAll = ctlWe & ctlWdata[1];

  // pair bits: (0,1)=0 (0,2)=1 (0,3)=2 (1,2)=3 (1,3)=4 (2,3)=5; 1 = higher way more recent
  function automatic logic [LRU_W-1:0] lruUse(input logic [LRU_W-1:0] cur, input logic [WAY_BITS-1:0] k);
    logic [LRU_W-1:0] n;
    n = cur;
    case (k)
      2'd0: n[2:0] = 3'b000;
      2'd1: begin n[0] = 1'b1; n[4:3] = 2'b00; end
      2'd2: begin n[1] = 1'b1; n[3] = 1'b1; n[5] = 1'b0; end
      default: begin n[2] = 1'b1; n[4] = 1'b1; n[5] = 1'b1; end
    endcase
    return n;
  endfunction

  function automatic logic [WAY_BITS-1:0] lruOldest(input logic [LRU_W-1:0] l, input logic tw);
    if (tw)                                   return l[5] ? 2'd2 : 2'd3;
    if (!l[2] && !l[4] && !l[5])              return 2'd3;
    if ( l[5] && !l[1] && !l[3])              return 2'd2;
    if ( l[3] &&  l[4] && !l[0])              return 2'd1;
    if ( l[0] &&  l[1] &&  l[2])              return 2'd0;
    return 2'd3;
  endfunction

  assign ramAcc     = twoWay && (region == REGION_RAM);
  assign throughAcc = (region == REGION_THRU) || (region == REGION_RAM && !twoWay);
  assign cacheMask  = twoWay ? 4'b1100 : 4'b1111;
  assign ramWay     = {1'b0, cpuAddr[TAG_LSB]};
  assign victimNow  = lruOldest(lruArr[setIdx], twoWay);

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign hitVec[w]   = cacheMask[w] && validArr[setIdx][w] && (tagArr[w][setIdx] == tagIn);
    assign purgeHit[w] = cacheMask[w] && validArr[pSet][w] && (tagArr[w][pSet] == pTag);
  end

  always_comb begin
    hitWay = '0;
    for (int w = 0; w < NWAYS; w++)
      if (hitVec[w]) hitWay = WAY_BITS'(w);
  end

  assign cpuRdata = strb.selCap ? capReg :
                    ramAcc      ? dataArr[ramWay][setIdx][wordIdx] :
                                  dataArr[hitWay][setIdx][wordIdx];
  assign memAddr  = strb.fillAddr ? {cpuAddr[AW-1:OFF_BITS], fillCnt, 2'b00} : cpuAddr;
  assign memWdata = strb.tasData ? (capReg | {1'b1, {(DW-1){1'b0}}}) : cpuWdata;

  always_ff @(posedge clk) begin
    if (strb.fillWrite) dataArr[victimReg][setIdx][fillCnt] <= memRdata;
    if (strb.writeHit)  dataArr[hitWay][setIdx][wordIdx]    <= cpuWdata;
    if (strb.ramWrite)  dataArr[ramWay][setIdx][wordIdx]    <= cpuWdata;
    if (strb.fillDone)  tagArr[victimReg][setIdx]           <= tagIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      twoWay    <= 1'b0;
      victimReg <= '0;
      capReg    <= '0;
    end else begin
      if (ctlWe)          twoWay    <= ctlWdata[0];
      if (strb.fillStart) victimReg <= victimNow;
      if (strb.capture)   capReg    <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || purgeAll) begin
      for (int s = 0; s < NSETS; s++) begin
        validArr[s] <= '0;
        lruArr[s]   <= '0;
      end
    end else begin
      if (strb.fillDone) begin
        validArr[setIdx][victimReg] <= 1'b1;
        lruArr[setIdx] <= lruUse(lruArr[setIdx], victimReg);
      end
      if (strb.lruTouch) lruArr[setIdx] <= lruUse(lruArr[setIdx], hitWay);
      if (strb.purgeLine)
        for (int w = 0; w < NWAYS; w++)
          if (purgeHit[w]) validArr[pSet][w] <= 1'b0;
    end
  end
endmodule

// File: rtl/split_cache_ctrl.sv
`timescale 1ns/1ps
module split_cache_ctrl
  import split_cache_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuReq,
  input  logic                 cpuWe,
  input  logic                 cpuAtomic,
  input  logic                 purgeReq,
  input  logic                 hit,
  input  logic                 ramAcc,
  input  logic                 throughAcc,
  input  logic                 memAck,
  output ctlStrobes_t          strb,
  output logic [WORD_BITS-1:0] fillCnt,
  output logic                 cpuReady,
  output logic                 memReq,
  output logic                 memWe,
  output logic                 memLock
);
  typedef enum logic [2:0] {S_IDLE, S_FILL, S_MEMOP, S_TASRD, S_TASWR, S_DONE} state_t;
  state_t state, stateNx;

  always_comb begin
    stateNx  = state;
    strb     = '0;
    cpuReady = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    memLock  = 1'b0;
    case (state)
      S_IDLE: begin
        if (purgeReq) strb.purgeLine = 1'b1;
        else if (cpuReq) begin
          if (cpuAtomic)                 stateNx = S_TASRD;
          else if (ramAcc) begin
            cpuReady      = 1'b1;
            strb.ramWrite = cpuWe;
          end
          else if (throughAcc || cpuWe)  stateNx = S_MEMOP;
          else if (hit) begin
            cpuReady      = 1'b1;
            strb.lruTouch = 1'b1;
          end else begin
            strb.fillStart = 1'b1;
            stateNx        = S_FILL;
          end
        end
      end
      S_FILL: begin
        memReq        = 1'b1;
        strb.fillAddr = 1'b1;
        if (memAck) begin
          strb.fillWrite = 1'b1;
          if (fillCnt == WORD_BITS'(NWORDS - 1)) begin
            strb.fillDone = 1'b1;
            stateNx       = S_IDLE;
          end
        end
      end
      S_MEMOP: begin
        memReq = 1'b1;
        memWe  = cpuWe;
        if (memAck) begin
          strb.capture  = !cpuWe;
          strb.writeHit = cpuWe && hit && !throughAcc;
          strb.lruTouch = cpuWe && hit && !throughAcc;
          stateNx       = S_DONE;
        end
      end
      S_TASRD: begin
        memReq  = 1'b1;
        memLock = 1'b1;
        if (memAck) begin
          strb.capture = 1'b1;
          stateNx      = S_TASWR;
        end
      end
      S_TASWR: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        memLock      = 1'b1;
        strb.tasData = 1'b1;
        if (memAck) stateNx = S_DONE;
      end
      default: begin
        cpuReady    = 1'b1;
        strb.selCap = 1'b1;
        stateNx     = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      fillCnt <= '0;
    end else begin
      state <= stateNx;
      if (state == S_FILL && memAck) fillCnt <= fillCnt + 1'b1;
    end
  end
endmodule

// File: rtl/split_cache.sv
`timescale 1ns/1ps
module split_cache
  import split_cache_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuAtomic,
  input  logic [AW-1:0]     cpuAddr,
  input  logic [DW-1:0]     cpuWdata,
  output logic [DW-1:0]     cpuRdata,
  output logic              cpuReady,
  input  logic              ctlWe,
  input  logic [1:0]        ctlWdata,
  input  logic              purgeReq,
  input  logic [LINE_W-1:0] purgeLineAddr,
  output logic              memReq,
  output logic              memWe,
  output logic              memLock,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  input  logic [DW-1:0]     memRdata,
  input  logic              memAck
);
  ctlStrobes_t          strb;
  logic [WORD_BITS-1:0] fillCnt;
  logic                 twoWay, ramAcc, throughAcc;
  logic [NWAYS-1:0]     hitVec;

  split_cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAtomic(cpuAtomic),
    .purgeReq(purgeReq), .hit(|hitVec), .ramAcc(ramAcc), .throughAcc(throughAcc),
    .memAck(memAck), .strb(strb), .fillCnt(fillCnt), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memLock(memLock)
  );

  split_cache_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fillCnt(fillCnt), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .ctlWe(ctlWe), .ctlWdata(ctlWdata), .purgeLineAddr(purgeLineAddr),
    .memRdata(memRdata), .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata),
    .twoWay(twoWay), .hitVec(hitVec), .ramAcc(ramAcc), .throughAcc(throughAcc)
  );
endmodule

// File: rtl/split_cache_chk.sv
`timescale 1ns/1ps
module split_cache_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuReq,
  input logic        cpuAtomic,
  input logic [2:0]  cpuRegion,
  input logic        memReq,
  input logic        memWe,
  input logic        memLock,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic        memTopBit,
  input logic        twoWay,
  input logic [3:0]  hitVec
);
  // R10: lock only travels with a live request
  p_lock_with_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    memLock |-> memReq);

  // R10: the locked write sets bit 31
  p_tas_sets_bit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memLock && memWe) |-> memTopBit);

  // R11: request fields held until acknowledged
  p_req_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R9: RAM window in two-way mode never reaches the external port
  p_ram_local_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuAtomic && twoWay && cpuRegion == 3'b110) |-> !memReq);

  // R12: no two ways match
  p_single_hit_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));
endmodule

bind split_cache split_cache_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuAtomic(cpuAtomic),
  .cpuRegion(cpuAddr[31:29]), .memReq(memReq), .memWe(memWe), .memLock(memLock),
  .memAck(memAck), .memAddr(memAddr), .memTopBit(memWdata[31]),
  .twoWay(twoWay), .hitVec(hitVec)
);

// File: tb/split_cache_bench.sv
`timescale 1ns/1ps
module split_cache_bench;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        cpuReq = 0, cpuWe = 0, cpuAtomic = 0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0, cpuRdata;
  logic        cpuReady;
  logic        ctlWe = 0;
  logic [1:0]  ctlWdata = '0;
  logic        purgeReq = 0;
  logic [27:0] purgeLineAddr = '0;
  logic        memReq, memWe, memLock;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  int nTests = 0, nFail = 0;
  int nRd = 0, nWr = 0, nLockRd = 0, nLockWr = 0;
  logic [31:0] rdLog [16];
  logic [31:0] lastWrAddr, lastWrData;
  logic [31:0] extMem [logic [31:0]];
  logic [31:0] rd;
  int          wc;

  always #10 clk = ~clk;

  split_cache u_split_cache (.*);

  function automatic logic [31:0] memVal(input logic [31:0] a);
    return extMem.exists(a) ? extMem[a] : (a ^ 32'h1357_0000);
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        memAck = 1'b1;
        if (memWe) begin
          extMem[memAddr] = memWdata;
          lastWrAddr = memAddr; lastWrData = memWdata;
          nWr++; if (memLock) nLockWr++;
        end else begin
          memRdata = memVal(memAddr);
          rdLog[nRd % 16] = memAddr;
          nRd++; if (memLock) nLockRd++;
        end
      end else memAck = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic atom, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuReq = 1; cpuWe = we; cpuAtomic = atom; cpuAddr = a; cpuWdata = d;
    wc = 0;
    #1;
    while (!cpuReady && wc < 300) begin @(negedge clk); #1; wc++; end
    rd = cpuRdata;
    @(negedge clk);
    cpuReq = 0; cpuWe = 0; cpuAtomic = 0;
  endtask

  task automatic ctlWrite(input logic [1:0] v);
    @(negedge clk); ctlWe = 1; ctlWdata = v;
    @(negedge clk); ctlWe = 0;
  endtask

  task automatic purgeOne(input logic [31:0] a);
    @(negedge clk); purgeReq = 1; purgeLineAddr = a[31:4];
    @(negedge clk); purgeReq = 0;
  endtask

  // read and check data plus number of external reads it caused
  task automatic readChk(input string req, input logic [31:0] a, input int expRd);
    int b;
    b = nRd;
    access(0, 0, a, '0);
    chk({req, " data"}, rd, memVal(a));
    chk({req, " ext reads"}, 32'(nRd - b), 32'(expRd));
  endtask

  task automatic tReset();
    chk("R1 ready", {31'b0, cpuReady}, 0);
    chk("R1 memReq", {31'b0, memReq}, 0);
    chk("R1 memLock", {31'b0, memLock}, 0);
    readChk("R1 first read misses", 32'h0000_0A00, 4);
  endtask

  task automatic tFillHit();
    int b;
    b = nRd;
    readChk("R2 miss", 32'h0000_1234, 4);
    chk("R2 fill first addr", rdLog[b % 16], 32'h0000_1230);
    chk("R2 fill last addr", rdLog[(b + 3) % 16], 32'h0000_123C);
    readChk("R2 hit", 32'h0000_1234, 0);
    chk("R2 hit same cycle", 32'(wc), 0);
    readChk("R2 other word hit", 32'h0000_1238, 0);
  endtask

  task automatic tLru4();
    ctlWrite(2'b10);
    for (int n = 1; n <= 4; n++) readChk("R3 fill", 32'(n << 10) | 32'h50, 4);
    readChk("R3 fifth tag", 32'h0000_1450, 4);
    readChk("R3 recent kept", 32'h0000_0850, 0);
    readChk("R3 oldest evicted", 32'h0000_0450, 4);
    ctlWrite(2'b10);
    for (int n = 1; n <= 4; n++) readChk("R3 refill", 32'(n << 10) | 32'h60, 4);
    readChk("R3 touch", 32'h0000_0460, 0);
    readChk("R3 new tag", 32'h0000_1460, 4);
    readChk("R3 touched kept", 32'h0000_0460, 0);
    readChk("R3 second oldest evicted", 32'h0000_0860, 4);
  endtask

  task automatic tWrite();
    int b, r;
    ctlWrite(2'b10);
    readChk("R4 prime", 32'h0000_2000, 4);
    b = nWr;
    access(1, 0, 32'h0000_2000, 32'hDEAD_BEEF);
    chk("R4 write hit ext count", 32'(nWr - b), 1);
    chk("R4 write addr", lastWrAddr, 32'h0000_2000);
    chk("R4 write data", lastWrData, 32'hDEAD_BEEF);
    r = nRd;
    access(0, 0, 32'h0000_2000, '0);
    chk("R4 updated line", rd, 32'hDEAD_BEEF);
    chk("R4 updated line no fetch", 32'(nRd - r), 0);
    access(1, 0, 32'h0000_3000, 32'h0BAD_F00D);
    chk("R4 write miss ext count", 32'(nWr - b), 2);
    readChk("R4 no allocate", 32'h0000_3000, 4);
    chk("R4 miss data in memory", rd, 32'h0BAD_F00D);
  endtask

  task automatic tThrough();
    int b;
    readChk("R5 through read 1", 32'h2000_0100, 1);
    readChk("R5 through read 2", 32'h2000_0100, 1);
    b = nWr;
    access(1, 0, 32'h2000_0104, 32'h1111_2222);
    chk("R5 through write", 32'(nWr - b), 1);
    chk("R5 through write addr", lastWrAddr, 32'h2000_0104);
  endtask

  task automatic tPurgeAll();
    readChk("R6 prime", 32'h0000_6070, 4);
    readChk("R6 primed hit", 32'h0000_6070, 0);
    ctlWrite(2'b10);
    readChk("R6 purged", 32'h0000_6070, 4);
    readChk("R6 purge bit not kept", 32'h0000_6070, 0);
    readChk("R6 mode stays four-way", 32'hC000_0050, 1);
  endtask

  task automatic tPurgeLine();
    ctlWrite(2'b10);
    readChk("R7 prime P", 32'h0000_4060, 4);
    readChk("R7 prime Q", 32'h0000_4460, 4);
    purgeOne(32'h0000_4068);
    readChk("R7 Q kept", 32'h0000_4460, 0);
    readChk("R7 P gone", 32'h0000_4060, 4);
  endtask

  task automatic tTas();
    int r, w, lr, lw;
    logic [31:0] old;
    readChk("R10 prime", 32'h0000_5000, 4);
    old = memVal(32'h0000_5000);
    r = nRd; w = nWr; lr = nLockRd; lw = nLockWr;
    access(0, 1, 32'h0000_5000, '0);
    chk("R10 returns old", rd, old);
    chk("R10 one ext read", 32'(nRd - r), 1);
    chk("R10 one ext write", 32'(nWr - w), 1);
    chk("R10 read locked", 32'(nLockRd - lr), 1);
    chk("R10 write locked", 32'(nLockWr - lw), 1);
    chk("R10 write addr", lastWrAddr, 32'h0000_5000);
    chk("R10 write data", lastWrData, old | 32'h8000_0000);
    chk("R11 lock released", {31'b0, memLock}, 0);
  endtask

  task automatic tTwoWay();
    int r, w;
    ctlWrite(2'b11);
    r = nRd; w = nWr;
    access(1, 0, 32'hC000_0050, 32'hAAAA_0001);
    chk("R9 ram write same cycle", 32'(wc), 0);
    access(1, 0, 32'hC000_0450, 32'hBBBB_0002);
    access(0, 0, 32'hC000_0050, '0);
    chk("R9 ram way0", rd, 32'hAAAA_0001);
    chk("R9 ram read same cycle", 32'(wc), 0);
    access(0, 0, 32'hC000_0450, '0);
    chk("R9 ram way1", rd, 32'hBBBB_0002);
    chk("R9 no ext traffic", 32'((nRd - r) + (nWr - w)), 0);
    readChk("R8 fill A", 32'h0000_0450, 4);
    readChk("R8 fill B", 32'h0000_0850, 4);
    readChk("R8 fill C", 32'h0000_0C50, 4);
    readChk("R8 B kept", 32'h0000_0850, 0);
    readChk("R8 A evicted", 32'h0000_0450, 4);
    access(0, 0, 32'hC000_0050, '0);
    chk("R9 ram way0 after fills", rd, 32'hAAAA_0001);
    access(0, 0, 32'hC000_0450, '0);
    chk("R9 ram way1 after fills", rd, 32'hBBBB_0002);
    ctlWrite(2'b10);
    readChk("R6 back to four-way ram window external", 32'hC000_0450, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    tReset();
    tFillHit();
    tLru4();
    tWrite();
    tThrough();
    tPurgeAll();
    tPurgeLine();
    tTas();
    tTwoWay();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule